// File: doc/BRIEF.md
# Per-Device Row Address Scrambler

Each memory device in a rank receives the same row address from the controller on every activate. This block sits inside one device and turns that shared external row into an internal physical row by a circular left rotation whose amount comes from a small identity value held in a configuration register. Different devices hold different identities, so the same external row lands on different internal rows in each of them. The physical neighbours of a heavily activated row therefore differ from device to device. Any disturbance an aggressor causes falls on unrelated external addresses in each device, which keeps the damage for a given external address within one device.

Configuration arrives through a register write port made of an address, a data byte and a one-cycle strobe. Activates arrive as a valid flag with a 16-bit row. The translated row leaves on a registered output one clock later.

Top module: `row_scrambler`

## Requirements
- R1: After reset the identity is 0, out_valid is 0, and an activate passes its row through unchanged: external 0x0001 gives 0x0001.
- R2: The output row equals the input row rotated left circularly by twice the identity. Bits that leave at bit 15 re-enter at bit 0.
- R3: The rotation amount is (2 × identity) modulo 16. Identity 8 behaves as identity 0, and identity 9 behaves as identity 1.
- R4: With identity 1, 0x0001 maps to 0x0004 and 0x0002 maps to 0x0008. With identity 2, 0x0001 maps to 0x0010 and 0x0002 maps to 0x0020.
- R5: A write with the strobe high to register address 0x3F loads data bits [3:0] into the identity. Data bits [7:4] are ignored.
- R6: A write to any register address other than 0x3F leaves the identity unchanged.
- R7: An activate in the same cycle as an identity write uses the old identity. The first activate in a later cycle uses the new one.
- R8: out_valid equals in_valid delayed by exactly one clock. out_row is updated only on a cycle that follows an accepted activate, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_data | input | 8 | Register write data |
| in_valid | input | 1 | Activate request |
| in_row | input | 16 | External row address |
| out_valid | output | 1 | Translated row valid |
| out_row | output | 16 | Internal physical row |

## Verification
A translated row is due exactly one clock after the activate that carries it. An identity write first affects an activate issued one cycle after the write. The bench drives inputs on the falling edge and samples the outputs on the falling edge after the next rising edge, so each check sees exactly the cycle it targets. Expected rows come from a bench rotation function that uses a model identity, and the bench updates that model only after the write edge. Same-cycle write-and-activate cases therefore expect the old mapping.

// File: rtl/row_scrambler_pkg.sv
package row_scrambler_pkg;
    localparam int ROW_W   = 16;
    localparam int ID_W    = 4;
    localparam int CADDR_W = 8;
    localparam int CDATA_W = 8;
    localparam logic [CADDR_W-1:0] ID_REG_ADDR = 8'h3F;
    localparam int SHIFT_W = $clog2(ROW_W);

    typedef logic [ROW_W-1:0] row_t;
    typedef logic [ID_W-1:0]  dev_id_t;
endpackage

// File: rtl/rs_id_reg.sv
module rs_id_reg
    import row_scrambler_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CADDR_W-1:0]  addr,
    input  logic [CDATA_W-1:0]  data,
    output dev_id_t             id_q
);
    typedef struct packed {
        dev_id_t id;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && addr == ID_REG_ADDR)
            st_d.id = data[ID_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign id_q = st_q.id;

    // R6
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == ID_REG_ADDR) |=> $stable(id_q));
    // R5
    id_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ID_REG_ADDR) |=> id_q == $past(data[ID_W-1:0]));
endmodule

// File: rtl/rs_rotator.sv
module rs_rotator
    import row_scrambler_pkg::*;
(
    input  row_t                row_i,
    input  logic [SHIFT_W-1:0]  amt,
    output row_t                row_o
);
    localparam int STAGES = SHIFT_W;
    row_t stage [STAGES+1];

    assign stage[0] = row_i;
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt[s]
            ? {stage[s][ROW_W-1-SH:0], stage[s][ROW_W-1 -: SH]}
            : stage[s];
    end
    assign row_o = stage[STAGES];
endmodule

// File: rtl/row_scrambler.sv
module row_scrambler
    import row_scrambler_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_data,
    input  logic        in_valid,
    input  logic [15:0] in_row,
    output logic        out_valid,
    output logic [15:0] out_row
);
    typedef struct packed {
        logic valid;
        row_t row;
    } st_t;

    st_t                 st_d, st_q;
    dev_id_t             id_q;
    logic [SHIFT_W-1:0]  amt;
    row_t                rot_row;

    rs_id_reg i_id (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .addr(cfg_addr), .data(cfg_data), .id_q(id_q)
    );

    // modulo-ROW_W rotation amount: 2*id truncated to SHIFT_W bits
    assign amt = SHIFT_W'({id_q, 1'b0});

    rs_rotator i_rot (.row_i(in_row), .amt(amt), .row_o(rot_row));

    always_comb begin
        st_d = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.row = rot_row;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_row   = st_q.row;

    // R8
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
    // R8
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_row));
    // R2
    popcnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $countones(out_row) == $countones($past(in_row)));
    // R1
    id0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && id_q[2:0] == 3'd0) |=> out_row == $past(in_row));
endmodule

// File: tb/test_row_scrambler.sv
module test_row_scrambler;
    logic clk = 0, rst_n = 0, cfg_we = 0, in_valid = 0;
    logic [7:0] cfg_addr = 0, cfg_data = 0;
    logic [15:0] in_row = 0;
    logic out_valid;
    logic [15:0] out_row;
    int checks = 0, errors = 0;
    logic [3:0] mid = 0;

    always #2 clk = ~clk;

    row_scrambler i_row_scrambler (.*);

    function automatic logic [15:0] rotl(input logic [15:0] r, input logic [3:0] id);
        int n = (2 * id) % 16;
        return 16'((r << n) | (r >> (16 - n)));
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(); @(posedge clk); @(negedge clk); endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_data = d;
        cyc();
        cfg_we = 0;
        if (a == 8'h3F) mid = d[3:0];
    endtask

    task automatic act(input logic [15:0] r, input logic [15:0] exp, input string req);
        in_valid = 1; in_row = r;
        cyc();
        in_valid = 0;
        chk(req, {15'd0, out_valid}, 16'd1);
        chk(req, out_row, exp);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd1234));
        @(negedge clk); cyc(); rst_n = 1; cyc();
        chk("R1 valid", {15'd0, out_valid}, 16'd0);
        act(16'h0001, 16'h0001, "R1");
        wr(8'h3F, 8'h01);
        act(16'h0001, 16'h0004, "R4");
        act(16'h0002, 16'h0008, "R4");
        wr(8'h3F, 8'hF2);
        chk("R5 high bits", 16'(mid), 16'd2);
        act(16'h0001, 16'h0010, "R5");
        act(16'h0002, 16'h0020, "R4");
        wr(8'h3E, 8'h07);
        act(16'h0001, 16'h0010, "R6");
        wr(8'h00, 8'h05);
        act(16'h8001, rotl(16'h8001, 4'd2), "R6");
        wr(8'h3F, 8'h07);
        act(16'hC003, 16'hF000, "R2 wrap");
        wr(8'h3F, 8'h08);
        act(16'h1234, 16'h1234, "R3");
        wr(8'h3F, 8'h09);
        act(16'h0001, 16'h0004, "R3");
        // R7: write and activate in the same cycle
        cfg_we = 1; cfg_addr = 8'h3F; cfg_data = 8'h03;
        in_valid = 1; in_row = 16'h0001;
        cyc();
        cfg_we = 0; in_valid = 0;
        chk("R7 old id", out_row, 16'h0004);
        mid = 4'd3;
        act(16'h0001, 16'h0040, "R7 new id");
        // R8: no activate -> out_valid low, row held
        held = out_row;
        in_row = 16'hFFFF; cyc();
        chk("R8 valid", {15'd0, out_valid}, 16'd0);
        chk("R8 hold", out_row, held);
        for (int i = 0; i < 300; i++) begin
            logic v;
            logic [15:0] r;
            if ($urandom % 5 == 0) wr(($urandom % 2) ? 8'h3F : 8'($urandom), 8'($urandom));
            v = 1'($urandom); r = 16'($urandom);
            held = out_row;
            in_valid = v; in_row = r;
            cyc();
            in_valid = 0;
            chk("R8 rnd valid", {15'd0, out_valid}, {15'd0, v});
            chk("R2 rnd", out_row, v ? rotl(r, mid) : held);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule